// File: doc/BRIEF.md
# Four-coordinate elliptic-curve point add/double sequencer

This block computes one elliptic-curve group operation over a prime field GF(p). Points are held in a four-coordinate projective form (X, Y, Z, V), where V carries the curve constant times Z to the fourth power. One command selects either doubling of a projective point, or mixed addition of an affine point (x, y) to a projective point. The scalar loop around the block issues these commands. Converting the result back to affine form is done elsewhere.

The datapath has one multi-cycle modular multiplier and one single-cycle modular adder/subtractor. A fixed 14-entry micro-step list per operation drives both. A step may pair one multiply with one add or subtract. In that case both operands of each lane are read from the register state as it was before the step, and both results are written in the same clock edge at the end of the step. Six temporaries plus the four result coordinates form the register file. The inputs are captured when a command is accepted.

The controller is a three-state machine with these states:
- **IDLE**: it waits and holds the last result with done high.
- **ISSUE**: it reads the current micro-step. An add-only step is written at once and stays in ISSUE, or returns to IDLE if it is the last step. A step with a multiply starts the multiplier and moves to MULWAIT.
- **MULWAIT**: it waits for the multiplier, writes both lanes, and goes to ISSUE, or to IDLE after the last step, raising done.

The transitions are IDLE→ISSUE on an accepted start, ISSUE→ISSUE, ISSUE→MULWAIT, ISSUE→IDLE, MULWAIT→MULWAIT, MULWAIT→ISSUE and MULWAIT→IDLE.

Top module: `mjac_point_seq`

## Requirements
- R1: After reset, done is 0 and all four result coordinates are 0.
- R2: With op = 0 (double), the result is the doubling schedule applied to (qx, qy, qz, qv): T1=qy², T2=2qx; T3=T1², T2=2T2; T1=T2·T1, T3=2T3; T2=qx², T3=2T3; T4=qy·qz, T3=2T3; T5=T3·qv, T6=2T2; T2=T6+T2; T2=T2+qv; T6=T2², rz=2T4; T4=2T1; rx=T6−T4; T1=T1−rx; T2=T2·T1, rv=2T5; ry=T2−T3. All arithmetic is mod p.
- R3: With op = 1 (mixed add), the result is the addition schedule applied to affine (px, py), projective (qx, qy, qz, qv) and constant ca: T1=qz²; T2=px·T1; T1=T1·qz, T3=qx−T2; T1=py·T1; T4=T3², T5=qy−T1; T2=T2·T4; T4=T4·T3, T6=2T2; rz=qz·T3, T6=T4+T6; T3=T5²; T1=T1·T4, rx=T3−T6; rv=rz², T2=T2−rx; T3=T5·T2; rv=rv², ry=T3−T1; rv=ca·rv. All arithmetic is mod p.
- R4: A double raises done exactly 8·(WIDTH+2)+6 clock edges after the edge that accepts start, independent of operand values.
- R5: A mixed add raises done exactly 14·(WIDTH+2) clock edges after the edge that accepts start, independent of operand values.
- R6: Done falls on the edge that accepts start. Once high, done and the result coordinates stay unchanged until the next accepted start.
- R7: While an operation is running, start, op and all operand inputs are ignored. The result and the latency are those of the accepted command.
- R8: For inputs below p, including 0 and p−1, every result coordinate and every multiplier product is below p. Subtraction adds p on a negative difference, and addition subtracts p on a sum of at least p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, accepted only when idle |
| op | input | 1 | 0 = double, 1 = mixed add |
| px | input | WIDTH | Affine x of the added point |
| py | input | WIDTH | Affine y of the added point |
| qx | input | WIDTH | Projective X input |
| qy | input | WIDTH | Projective Y input |
| qz | input | WIDTH | Projective Z input |
| qv | input | WIDTH | Projective V input |
| ca | input | WIDTH | Curve constant a |
| done | output | 1 | Result valid, held until next accepted start |
| rx | output | WIDTH | Result X |
| ry | output | WIDTH | Result Y |
| rz | output | WIDTH | Result Z |
| rv | output | WIDTH | Result V |

## Verification
The checker checks the following on every cycle:
- the latency from accept to the rise of done, per operation (R4, R5);
- done falling on acceptance and then holding with stable coordinates;
- that done never shows while busy;
- that multiplier products and outputs stay reduced below p.

Only the bench scenarios can show that the coordinates equal the two schedules (R2, R3). They also show that a start or operand change in mid-run leaves the outcome untouched (R7), and that the field edge values 0 and p−1 come out right. The bench compares these against a software modular model over a sweep of operand sets on a small modulus.

// File: rtl/mjac_pkg.sv
package mjac_pkg;

    localparam int STEPS = 14;
    localparam int NREG  = 10;
    localparam int NIN   = 7;
    localparam int NSRC  = 32;

    typedef logic [4:0] code_t;

    // register file entries
    localparam code_t C_T1 = 5'd0;
    localparam code_t C_T2 = 5'd1;
    localparam code_t C_T3 = 5'd2;
    localparam code_t C_T4 = 5'd3;
    localparam code_t C_T5 = 5'd4;
    localparam code_t C_T6 = 5'd5;
    localparam code_t C_X3 = 5'd6;
    localparam code_t C_Y3 = 5'd7;
    localparam code_t C_Z3 = 5'd8;
    localparam code_t C_V3 = 5'd9;
    // captured inputs (read only)
    localparam code_t C_QX = 5'd10;
    localparam code_t C_QY = 5'd11;
    localparam code_t C_QZ = 5'd12;
    localparam code_t C_QV = 5'd13;
    localparam code_t C_PX = 5'd14;
    localparam code_t C_PY = 5'd15;
    localparam code_t C_CA = 5'd16;

    typedef struct packed {
        logic  mul_en;
        code_t ma;
        code_t mb;
        code_t md;
        logic  add_en;
        logic  sub;
        code_t aa;
        code_t ab;
        code_t ad;
    } uop_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_MULWAIT
    } st_t;

endpackage

// File: rtl/mjac_addsub.sv
module mjac_addsub #(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] MODULUS = 16'hFFF1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] y
);
    localparam logic [WIDTH:0] PW = {1'b0, MODULUS};

    logic [WIDTH:0] sum_w;
    logic [WIDTH:0] dif_w;

    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b};
        dif_w = {1'b0, a} - {1'b0, b};
        if (sub) begin
            if (dif_w[WIDTH]) y = dif_w[WIDTH-1:0] + MODULUS;
            else              y = dif_w[WIDTH-1:0];
        end else begin
            if (sum_w >= PW)  y = sum_w[WIDTH-1:0] - MODULUS;
            else              y = sum_w[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/mjac_mul.sv
module mjac_mul #(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] MODULUS = 16'hFFF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             done,
    output logic [WIDTH-1:0] res
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] acc;
    logic [WIDTH-1:0] areg;
    logic [WIDTH-1:0] breg;
    logic [CW-1:0]    cnt;
    logic             done_r;
    logic [WIDTH-1:0] dbl;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] addend;

    assign addend = areg[WIDTH-1] ? breg : '0;

    mjac_addsub #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_dbl (
        .a(acc), .b(acc), .sub(1'b0), .y(dbl)
    );

    mjac_addsub #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_acc (
        .a(dbl), .b(addend), .sub(1'b0), .y(nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            areg   <= '0;
            breg   <= '0;
            cnt    <= '0;
            done_r <= 1'b0;
        end else if (start) begin
            acc    <= '0;
            areg   <= a;
            breg   <= b;
            cnt    <= CW'(WIDTH);
            done_r <= 1'b0;
        end else if (cnt != '0) begin
            acc    <= nxt;
            areg   <= {areg[WIDTH-2:0], 1'b0};
            cnt    <= cnt - CW'(1);
            done_r <= (cnt == CW'(1));
        end else begin
            done_r <= 1'b0;
        end
    end

    assign done = done_r;
    assign res  = acc;
endmodule

// File: rtl/mjac_ucode.sv
module mjac_ucode
    import mjac_pkg::*;
(
    input  logic       op,
    input  logic [3:0] idx,
    output uop_t       uop
);
    function automatic uop_t u(input logic me, input code_t ma, input code_t mb,
                               input code_t md, input logic ae, input logic sb,
                               input code_t aa, input code_t ab, input code_t ad);
        uop_t r;
        r.mul_en = me; r.ma = ma; r.mb = mb; r.md = md;
        r.add_en = ae; r.sub = sb; r.aa = aa; r.ab = ab; r.ad = ad;
        return r;
    endfunction

    always_comb begin
        uop = '0;
        if (op) begin
            unique case (idx)
                4'd0:  uop = u(1, C_QZ, C_QZ, C_T1, 0, 0, C_T1, C_T1, C_T1);
                4'd1:  uop = u(1, C_PX, C_T1, C_T2, 0, 0, C_T1, C_T1, C_T1);
                4'd2:  uop = u(1, C_T1, C_QZ, C_T1, 1, 1, C_QX, C_T2, C_T3);
                4'd3:  uop = u(1, C_PY, C_T1, C_T1, 0, 0, C_T1, C_T1, C_T1);
                4'd4:  uop = u(1, C_T3, C_T3, C_T4, 1, 1, C_QY, C_T1, C_T5);
                4'd5:  uop = u(1, C_T2, C_T4, C_T2, 0, 0, C_T1, C_T1, C_T1);
                4'd6:  uop = u(1, C_T4, C_T3, C_T4, 1, 0, C_T2, C_T2, C_T6);
                4'd7:  uop = u(1, C_QZ, C_T3, C_Z3, 1, 0, C_T4, C_T6, C_T6);
                4'd8:  uop = u(1, C_T5, C_T5, C_T3, 0, 0, C_T1, C_T1, C_T1);
                4'd9:  uop = u(1, C_T1, C_T4, C_T1, 1, 1, C_T3, C_T6, C_X3);
                4'd10: uop = u(1, C_Z3, C_Z3, C_V3, 1, 1, C_T2, C_X3, C_T2);
                4'd11: uop = u(1, C_T5, C_T2, C_T3, 0, 0, C_T1, C_T1, C_T1);
                4'd12: uop = u(1, C_V3, C_V3, C_V3, 1, 1, C_T3, C_T1, C_Y3);
                4'd13: uop = u(1, C_CA, C_V3, C_V3, 0, 0, C_T1, C_T1, C_T1);
                default: uop = '0;
            endcase
        end else begin
            unique case (idx)
                4'd0:  uop = u(1, C_QY, C_QY, C_T1, 1, 0, C_QX, C_QX, C_T2);
                4'd1:  uop = u(1, C_T1, C_T1, C_T3, 1, 0, C_T2, C_T2, C_T2);
                4'd2:  uop = u(1, C_T2, C_T1, C_T1, 1, 0, C_T3, C_T3, C_T3);
                4'd3:  uop = u(1, C_QX, C_QX, C_T2, 1, 0, C_T3, C_T3, C_T3);
                4'd4:  uop = u(1, C_QY, C_QZ, C_T4, 1, 0, C_T3, C_T3, C_T3);
                4'd5:  uop = u(1, C_T3, C_QV, C_T5, 1, 0, C_T2, C_T2, C_T6);
                4'd6:  uop = u(0, C_T1, C_T1, C_T1, 1, 0, C_T6, C_T2, C_T2);
                4'd7:  uop = u(0, C_T1, C_T1, C_T1, 1, 0, C_T2, C_QV, C_T2);
                4'd8:  uop = u(1, C_T2, C_T2, C_T6, 1, 0, C_T4, C_T4, C_Z3);
                4'd9:  uop = u(0, C_T1, C_T1, C_T1, 1, 0, C_T1, C_T1, C_T4);
                4'd10: uop = u(0, C_T1, C_T1, C_T1, 1, 1, C_T6, C_T4, C_X3);
                4'd11: uop = u(0, C_T1, C_T1, C_T1, 1, 1, C_T1, C_X3, C_T1);
                4'd12: uop = u(1, C_T2, C_T1, C_T2, 1, 0, C_T5, C_T5, C_V3);
                4'd13: uop = u(0, C_T1, C_T1, C_T1, 1, 1, C_T2, C_T3, C_Y3);
                default: uop = '0;
            endcase
        end
    end
endmodule

// File: rtl/mjac_point_seq.sv
module mjac_point_seq
    import mjac_pkg::*;
#(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] MODULUS = 16'hFFF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op,
    input  logic [WIDTH-1:0] px,
    input  logic [WIDTH-1:0] py,
    input  logic [WIDTH-1:0] qx,
    input  logic [WIDTH-1:0] qy,
    input  logic [WIDTH-1:0] qz,
    input  logic [WIDTH-1:0] qv,
    input  logic [WIDTH-1:0] ca,
    output logic             done,
    output logic [WIDTH-1:0] rx,
    output logic [WIDTH-1:0] ry,
    output logic [WIDTH-1:0] rz,
    output logic [WIDTH-1:0] rv
);
    st_t              state;
    st_t              state_nx;
    logic [3:0]       idx;
    logic             op_r;
    logic             done_r;
    logic [WIDTH-1:0] rf   [NREG];
    logic [WIDTH-1:0] in_r [NIN];
    logic [WIDTH-1:0] srcv [NSRC];
    uop_t             uop;
    logic             accept;
    logic             busy;
    logic             last;
    logic             mul_start;
    logic             mul_done;
    logic [WIDTH-1:0] mul_a;
    logic [WIDTH-1:0] mul_b;
    logic [WIDTH-1:0] mul_res;
    logic [WIDTH-1:0] add_a;
    logic [WIDTH-1:0] add_b;
    logic [WIDTH-1:0] add_y;

    assign accept    = start && (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign last      = (idx == 4'(STEPS - 1));
    assign mul_start = (state == ST_ISSUE) && uop.mul_en;

    // operand source bus: register file, then captured inputs
    always_comb begin
        for (int i = 0; i < NSRC; i++) srcv[i] = '0;
        for (int i = 0; i < NREG; i++) srcv[i] = rf[i];
        for (int i = 0; i < NIN; i++)  srcv[NREG + i] = in_r[i];
    end

    assign mul_a = srcv[uop.ma];
    assign mul_b = srcv[uop.mb];
    assign add_a = srcv[uop.aa];
    assign add_b = srcv[uop.ab];

    mjac_ucode u_rom (
        .op  (op_r),
        .idx (idx),
        .uop (uop)
    );

    mjac_addsub #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_lane (
        .a   (add_a),
        .b   (add_b),
        .sub (uop.sub),
        .y   (add_y)
    );

    mjac_mul #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (mul_a),
        .b     (mul_b),
        .done  (mul_done),
        .res   (mul_res)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (uop.mul_en) state_nx = ST_MULWAIT;
                else if (last)  state_nx = ST_IDLE;
                else            state_nx = ST_ISSUE;
            end
            ST_MULWAIT: begin
                if (mul_done) state_nx = last ? ST_IDLE : ST_ISSUE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath, register file and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            op_r   <= 1'b0;
            done_r <= 1'b0;
            for (int i = 0; i < NREG; i++) rf[i]   <= '0;
            for (int i = 0; i < NIN; i++)  in_r[i] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        idx     <= '0;
                        op_r    <= op;
                        done_r  <= 1'b0;
                        in_r[0] <= qx;
                        in_r[1] <= qy;
                        in_r[2] <= qz;
                        in_r[3] <= qv;
                        in_r[4] <= px;
                        in_r[5] <= py;
                        in_r[6] <= ca;
                    end
                end
                ST_ISSUE: begin
                    if (!uop.mul_en) begin
                        if (uop.add_en && (uop.ad < code_t'(NREG))) rf[uop.ad] <= add_y;
                        idx <= idx + 4'd1;
                        if (last) done_r <= 1'b1;
                    end
                end
                ST_MULWAIT: begin
                    if (mul_done) begin
                        if (uop.md < code_t'(NREG)) rf[uop.md] <= mul_res;
                        if (uop.add_en && (uop.ad < code_t'(NREG))) rf[uop.ad] <= add_y;
                        idx <= idx + 4'd1;
                        if (last) done_r <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done = done_r;
    assign rx   = rf[C_X3];
    assign ry   = rf[C_Y3];
    assign rz   = rf[C_Z3];
    assign rv   = rf[C_V3];
endmodule

// File: rtl/mjac_point_seq_chk.sv
module mjac_point_seq_chk #(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] MODULUS = 16'hFFF1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [WIDTH-1:0] rx,
    input logic [WIDTH-1:0] ry,
    input logic [WIDTH-1:0] rz,
    input logic [WIDTH-1:0] rv,
    input logic             busy,
    input logic             op_r,
    input logic             mul_done,
    input logic [WIDTH-1:0] mul_res
);
    localparam int L_ADD = 14 * (WIDTH + 2);
    localparam int L_DBL = 8 * (WIDTH + 2) + 6;

    logic [15:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (start && !busy)   cnt <= '0;
        else if (busy)             cnt <= cnt + 16'd1;
    end

    AST_LATENCY_DBL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !op_r) |-> (int'(cnt) == L_DBL)); // R4
    AST_LATENCY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && op_r) |-> (int'(cnt) == L_ADD)); // R5
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!done && busy)); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable({rx, ry, rz, rv}))); // R6
    AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R7
    AST_OUT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rx < MODULUS && ry < MODULUS && rz < MODULUS && rv < MODULUS)); // R8
    AST_MUL_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |-> (mul_res < MODULUS)); // R8
endmodule

bind mjac_point_seq mjac_point_seq_chk #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .rx       (rx),
    .ry       (ry),
    .rz       (rz),
    .rv       (rv),
    .busy     (busy),
    .op_r     (op_r),
    .mul_done (mul_done),
    .mul_res  (mul_res)
);

// File: tb/mjac_point_seq_test.sv
module mjac_point_seq_test;
    localparam int W = 8;
    localparam int P = 251;
    localparam int L_ADD = 14 * (W + 2);
    localparam int L_DBL = 8 * (W + 2) + 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op = 1'b0;
    logic [W-1:0] px = '0, py = '0, qx = '0, qy = '0, qz = '0, qv = '0, ca = '0;
    logic         done;
    logic [W-1:0] rx, ry, rz, rv;

    int total = 0;
    int fails = 0;
    int seed  = 12345;

    always #5 clk = ~clk;

    mjac_point_seq #(.WIDTH(W), .MODULUS(8'(P))) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .px(px), .py(py), .qx(qx), .qy(qy), .qz(qz), .qv(qv), .ca(ca),
        .done(done), .rx(rx), .ry(ry), .rz(rz), .rv(rv)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mm(input int a, input int b); return (a * b) % P; endfunction
    function automatic int am(input int a, input int b); return (a + b) % P; endfunction
    function automatic int sm(input int a, input int b); return (a - b + P) % P; endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 32'h7fff) % P;
    endfunction

    task automatic model(input bit o, input int ax, input int ay, input int bx, input int by,
                         input int bz, input int bv, input int k,
                         output int ex, output int ey, output int ez, output int ev);
        int t1, t2, t3, t4, t5, t6;
        if (o) begin
            t1 = mm(bz, bz);
            t2 = mm(ax, t1);
            t1 = mm(t1, bz); t3 = sm(bx, t2);
            t1 = mm(ay, t1);
            t4 = mm(t3, t3); t5 = sm(by, t1);
            t2 = mm(t2, t4);
            t4 = mm(t4, t3); t6 = am(t2, t2);
            ez = mm(bz, t3); t6 = am(t4, t6);
            t3 = mm(t5, t5);
            t1 = mm(t1, t4); ex = sm(t3, t6);
            ev = mm(ez, ez); t2 = sm(t2, ex);
            t3 = mm(t5, t2);
            ev = mm(ev, ev); ey = sm(t3, t1);
            ev = mm(k, ev);
        end else begin
            t1 = mm(by, by); t2 = am(bx, bx);
            t3 = mm(t1, t1); t2 = am(t2, t2);
            t1 = mm(t2, t1); t3 = am(t3, t3);
            t2 = mm(bx, bx); t3 = am(t3, t3);
            t4 = mm(by, bz); t3 = am(t3, t3);
            t5 = mm(t3, bv); t6 = am(t2, t2);
            t2 = am(t6, t2);
            t2 = am(t2, bv);
            t6 = mm(t2, t2); ez = am(t4, t4);
            t4 = am(t1, t1);
            ex = sm(t6, t4);
            t1 = sm(t1, ex);
            t2 = mm(t2, t1); ev = am(t5, t5);
            ey = sm(t2, t3);
        end
    endtask

    // run one command; disturb pulses start with other operands mid-run
    task automatic run_op(input bit o, input int ax, input int ay, input int bx, input int by,
                          input int bz, input int bv, input int k, input bit disturb,
                          input bit edge_case);
        int ex, ey, ez, ev, lat;
        string rt, lt;
        model(o, ax, ay, bx, by, bz, bv, k, ex, ey, ez, ev);
        rt = disturb ? "R7" : (edge_case ? "R8" : (o ? "R3" : "R2"));
        lt = disturb ? "R7" : (o ? "R5" : "R4");
        @(negedge clk);
        op = o; px = W'(ax); py = W'(ay); qx = W'(bx); qy = W'(by);
        qz = W'(bz); qv = W'(bv); ca = W'(k); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R6 done low after accept", int'(done), 0);
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 20) begin
                start = 1'b1; op = ~o;
                px = ~px; py = py + 8'd3; qx = qx ^ 8'h5a; qy = ~qy;
                qz = qz + 8'd1; qv = qv ^ 8'h0f; ca = ca + 8'd7;
            end else begin
                start = 1'b0;
            end
        end
        chk(lat == (o ? L_ADD : L_DBL), {lt, " latency"}, lat, o ? L_ADD : L_DBL);
        chk(int'(rx) == ex, {rt, " rx"}, int'(rx), ex);
        chk(int'(ry) == ey, {rt, " ry"}, int'(ry), ey);
        chk(int'(rz) == ez, {rt, " rz"}, int'(rz), ez);
        chk(int'(rv) == ev, {rt, " rv"}, int'(rv), ev);
        chk(rx < P && ry < P && rz < P && rv < P, "R8 reduced", int'(rx), P - 1);
    endtask

    initial begin
        #2000000;
        total++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [W-1:0] hx, hy, hz, hv;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(rx == 0 && ry == 0 && rz == 0 && rv == 0, "R1 coords after reset",
            int'(rx) + int'(ry) + int'(rz) + int'(rv), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // field edge values
        run_op(1'b0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
        run_op(1'b1, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
        run_op(1'b0, P-1, P-1, P-1, P-1, P-1, P-1, P-1, 1'b0, 1'b1);
        run_op(1'b1, P-1, P-1, P-1, P-1, P-1, P-1, P-1, 1'b0, 1'b1);
        run_op(1'b1, 1, P-1, 0, P-1, 1, 0, P-1, 1'b0, 1'b1);
        run_op(1'b0, 0, 1, P-1, 1, P-1, 1, 0, 1'b0, 1'b1);

        // hold while idle
        hx = rx; hy = ry; hz = rz; hv = rv;
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R6 done held", int'(done), 1);
        chk(rx == hx && ry == hy && rz == hz && rv == hv, "R6 coords held", int'(rx), int'(hx));

        // start during a run is ignored
        run_op(1'b0, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b0);
        run_op(1'b1, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b0);

        // operand sweep, both operations
        for (int i = 0; i < 300; i++) begin
            run_op(i[0], rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), 1'b0, 1'b0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule